// File: doc/BRIEF.md
# Serial Port Host Handshake

This block sits between a host bus and the bit-level shift logic of a serial port. It keeps one transmit holding byte and one receive buffer byte. It raises a ready flag toward the host for each direction. It starts the transmit shifter only when the transmitter is enabled and the far end allows sending. The host's own data accesses clear the ready flags, so no separate acknowledge is needed.

The host drives one-cycle read and write strobes. They are qualified by a select line and by a command/data line. A data write fills the holding byte. A data read consumes the receive buffer, which is always visible on `rd_data`. A command write sets the transmit enable and can clear the overrun flag. Status reads are not implemented. The shift logic reports that it is idle and pulses when a frame is done. The receive side pulses once for each assembled character. While the transmitter does not own the line, the serial output rests at mark (logic 1).

Top module: `serial_host_hs`

## Requirements
- R1: While `rst_n` is low, and after its release, `tx_ready`, `rx_ready`, `overrun` and `tx_start` are 0 and `txd` is 1. Reset assertion is asynchronous. Release passes through a two-stage synchronizer.
- R2: A command write (`sel`=1, `is_cmd`=1, `wr_stb`=1) loads the transmit enable from `wr_data[0]`. `tx_ready` is 1 only while the enable is 1 and the holding byte is empty.
- R3: A data write (`sel`=1, `is_cmd`=0, `wr_stb`=1) loads `wr_data` into the holding byte and marks it full. `tx_ready` is 0 from the next cycle.
- R4: `tx_start` is 1 only while all four of these hold: the holding byte is full, the enable is 1, `cts_ok` is 1 and `shift_idle` is 1. During that cycle `tx_byte` shows the held byte. The holding byte is empty from the next cycle.
- R5: A `rx_done` pulse loads `rx_char` into the receive buffer shown on `rd_data`. `rx_ready` is 1 from the next cycle.
- R6: A data read (`sel`=1, `is_cmd`=0, `rd_stb`=1) without `rx_done` in the same cycle makes `rx_ready` 0 from the next cycle.
- R7: A strobe with `sel`=0 changes no flag. A read with `is_cmd`=1 changes no flag.
- R8: A `rx_done` while `rx_ready` is 1 and no data read occurs in that cycle overwrites the buffer and sets `overrun`.
- R9: A `rx_done` in the same cycle as a data read loads the new byte. `rx_ready` stays 1 and `overrun` is not set.
- R10: `overrun` stays set until a command write with `wr_data[4]`=1 clears it.
- R11: `txd` follows `shift_txd` from the cycle after `tx_start` until the cycle after a `shift_done` pulse. At all other times `txd` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Host select, active high |
| is_cmd | input | 1 | 1 = command access, 0 = data access |
| rd_stb | input | 1 | Host read strobe, one cycle |
| wr_stb | input | 1 | Host write strobe, one cycle |
| wr_data | input | 8 | Host write data |
| rd_data | output | 8 | Receive buffer byte |
| rx_done | input | 1 | Character-assembled pulse from receive logic |
| rx_char | input | 8 | Assembled character |
| cts_ok | input | 1 | Clear-to-send asserted |
| shift_idle | input | 1 | Transmit shifter can take a byte |
| shift_done | input | 1 | Transmit shifter finished its frame |
| shift_txd | input | 1 | Serial bit from the transmit shifter |
| tx_ready | output | 1 | Holding byte can accept data |
| rx_ready | output | 1 | Receive buffer holds an unread character |
| overrun | output | 1 | A character was lost to overwrite |
| tx_start | output | 1 | Load request to the transmit shifter |
| tx_byte | output | 8 | Byte handed to the shifter |
| txd | output | 1 | Serial line output, mark when idle |

## Verification
A new character can finish in the same cycle as the host's data read. That cycle decides between a clean hand-over and an overrun. The bench provokes the collision in two ways. First, it pulses `rx_done` while the buffer is still unread and no read happens, and expects `overrun` and the newer byte on `rd_data`. Second, it issues a data read in the very cycle of `rx_done`, and expects `rx_ready` to stay high with the new byte and no change to `overrun`. A command write can likewise land in the same cycle as a start. The bench judges that case by `tx_ready`.

// File: rtl/shh_pkg.sv
package shh_pkg;
  // Decoded host access, one-hot or empty per cycle
  typedef struct packed {
    logic data_wr;
    logic data_rd;
    logic cmd_wr;
  } host_acc_t;
endpackage

// File: rtl/shh_decode.sv
module shh_decode
  import shh_pkg::*;
(
  input  logic      sel,
  input  logic      is_cmd,
  input  logic      rd_stb,
  input  logic      wr_stb,
  output host_acc_t acc
);
  always_comb begin
    acc.data_wr = sel & ~is_cmd & wr_stb;
    acc.data_rd = sel & ~is_cmd & rd_stb;
    acc.cmd_wr  = sel &  is_cmd & wr_stb;
  end
endmodule

// File: rtl/shh_tx.sv
module shh_tx
  import shh_pkg::*;
#(
  parameter int DW       = 8,
  parameter int EN_BIT   = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  host_acc_t     acc,
  input  logic [DW-1:0] wr_data,
  input  logic          cts_ok,
  input  logic          shift_idle,
  input  logic          shift_done,
  input  logic          shift_txd,
  output logic          tx_ready,
  output logic          tx_start,
  output logic [DW-1:0] tx_byte,
  output logic          txd
);
  logic [DW-1:0] hold_q;
  logic          full_q, full_d;
  logic          en_q, en_d;
  logic          own_q, own_d;
  logic          go;

  always_comb begin
    go     = full_q & en_q & cts_ok & shift_idle;
    full_d = full_q;
    if (go)          full_d = 1'b0;
    if (acc.data_wr) full_d = 1'b1;
    en_d   = acc.cmd_wr ? wr_data[EN_BIT] : en_q;
    own_d  = own_q;
    if (shift_done) own_d = 1'b0;
    if (go)         own_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      full_q <= 1'b0;
      en_q   <= 1'b0;
      own_q  <= 1'b0;
    end else begin
      if (acc.data_wr) hold_q <= wr_data;
      full_q <= full_d;
      en_q   <= en_d;
      own_q  <= own_d;
    end
  end

  assign tx_ready = en_q & ~full_q;
  assign tx_start = go;
  assign tx_byte  = hold_q;
  assign txd      = own_q ? shift_txd : 1'b1;
endmodule

// File: rtl/shh_rx.sv
module shh_rx
  import shh_pkg::*;
#(
  parameter int DW      = 8,
  parameter int CLR_BIT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  host_acc_t     acc,
  input  logic [DW-1:0] wr_data,
  input  logic          rx_done,
  input  logic [DW-1:0] rx_char,
  output logic          rx_ready,
  output logic          overrun,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] buf_q;
  logic          rdy_q, rdy_d;
  logic          ovr_q, ovr_d;

  always_comb begin
    rdy_d = rdy_q;
    if (acc.data_rd) rdy_d = 1'b0;
    if (rx_done)     rdy_d = 1'b1;
    ovr_d = ovr_q;
    if (acc.cmd_wr && wr_data[CLR_BIT])       ovr_d = 1'b0;
    if (rx_done && rdy_q && !acc.data_rd)     ovr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      rdy_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      if (rx_done) buf_q <= rx_char;
      rdy_q <= rdy_d;
      ovr_q <= ovr_d;
    end
  end

  assign rx_ready = rdy_q;
  assign overrun  = ovr_q;
  assign rd_data  = buf_q;
endmodule

// File: rtl/serial_host_hs.sv
module serial_host_hs
  import shh_pkg::*;
#(
  parameter int DW          = 8,
  parameter int EN_BIT      = 0,
  parameter int CLR_BIT     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          is_cmd,
  input  logic          rd_stb,
  input  logic          wr_stb,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic          rx_done,
  input  logic [DW-1:0] rx_char,
  input  logic          cts_ok,
  input  logic          shift_idle,
  input  logic          shift_done,
  input  logic          shift_txd,
  output logic          tx_ready,
  output logic          rx_ready,
  output logic          overrun,
  output logic          tx_start,
  output logic [DW-1:0] tx_byte,
  output logic          txd
);
  localparam int SW = (SYNC_STAGES < 1) ? 1 : SYNC_STAGES;

  logic [SW-1:0] rst_pipe;
  logic          rst_int_n;
  host_acc_t     acc, acc_g;

  // Reset: asynchronous entry, synchronous exit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SW-2 >= 0 ? SW-2 : 0 : 0], 1'b1} & {SW{1'b1}};
  end
  assign rst_int_n = rst_pipe[SW-1];

  shh_decode u_dec (
    .sel(sel), .is_cmd(is_cmd), .rd_stb(rd_stb), .wr_stb(wr_stb), .acc(acc)
  );

  // Accesses are ignored until the reset pipe has drained
  always_comb begin
    acc_g = acc;
    if (!rst_int_n) acc_g = '0;
  end

  shh_tx #(.DW(DW), .EN_BIT(EN_BIT)) u_tx (
    .clk(clk), .rst_n(rst_int_n), .acc(acc_g), .wr_data(wr_data),
    .cts_ok(cts_ok), .shift_idle(shift_idle), .shift_done(shift_done),
    .shift_txd(shift_txd), .tx_ready(tx_ready), .tx_start(tx_start),
    .tx_byte(tx_byte), .txd(txd)
  );

  shh_rx #(.DW(DW), .CLR_BIT(CLR_BIT)) u_rx (
    .clk(clk), .rst_n(rst_int_n), .acc(acc_g), .wr_data(wr_data),
    .rx_done(rx_done & rst_int_n), .rx_char(rx_char), .rx_ready(rx_ready),
    .overrun(overrun), .rd_data(rd_data)
  );
endmodule

// File: rtl/serial_host_hs_chk.sv
module serial_host_hs_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_ok,
  input logic          sel,
  input logic          is_cmd,
  input logic          rd_stb,
  input logic          wr_stb,
  input logic          rx_done,
  input logic [DW-1:0] rx_char,
  input logic [DW-1:0] rd_data,
  input logic          tx_start,
  input logic          tx_ready,
  input logic          rx_ready,
  input logic          overrun,
  input logic          shift_done,
  input logic          txd
);
  logic d_wr, d_rd, c_wr;
  assign d_wr = sel & ~is_cmd & wr_stb;
  assign d_rd = sel & ~is_cmd & rd_stb;
  assign c_wr = sel &  is_cmd & wr_stb;

  assert_wr_blocks_R3: assert property (@(posedge clk) disable iff (!rst_ok)
    d_wr |=> !tx_ready);

  assert_start_frees_R4: assert property (@(posedge clk) disable iff (!rst_ok)
    (tx_start && !d_wr && !c_wr) |=> tx_ready);

  assert_rx_load_R5: assert property (@(posedge clk) disable iff (!rst_ok)
    rx_done |=> (rx_ready && rd_data == $past(rx_char)));

  assert_rd_clears_R6: assert property (@(posedge clk) disable iff (!rst_ok)
    (d_rd && !rx_done) |=> !rx_ready);

  assert_overwrite_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    (rx_done && rx_ready && !d_rd) |=> overrun);

  assert_line_mark_R11: assert property (@(posedge clk) disable iff (!rst_ok)
    (shift_done && !tx_start) |=> txd);
endmodule

bind serial_host_hs serial_host_hs_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_ok(rst_int_n), .sel(sel), .is_cmd(is_cmd), .rd_stb(rd_stb),
  .wr_stb(wr_stb), .rx_done(rx_done), .rx_char(rx_char), .rd_data(rd_data),
  .tx_start(tx_start), .tx_ready(tx_ready), .rx_ready(rx_ready),
  .overrun(overrun), .shift_done(shift_done), .txd(txd)
);

// File: tb/serial_host_hs_test.sv
module serial_host_hs_test;
  logic       clk, rst_n;
  logic       sel, is_cmd, rd_stb, wr_stb;
  logic [7:0] wr_data, rd_data, rx_char, tx_byte;
  logic       rx_done, cts_ok, shift_idle, shift_done, shift_txd;
  logic       tx_ready, rx_ready, overrun, tx_start, txd;
  int         n_chk, n_bad;

  serial_host_hs uut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .is_cmd(is_cmd), .rd_stb(rd_stb),
    .wr_stb(wr_stb), .wr_data(wr_data), .rd_data(rd_data), .rx_done(rx_done),
    .rx_char(rx_char), .cts_ok(cts_ok), .shift_idle(shift_idle),
    .shift_done(shift_done), .shift_txd(shift_txd), .tx_ready(tx_ready),
    .rx_ready(rx_ready), .overrun(overrun), .tx_start(tx_start),
    .tx_byte(tx_byte), .txd(txd)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic       s, c, r, w;
    logic [7:0] wd;
    logic       rxd;
    logic [7:0] rxc;
    logic       cts, idle;
    logic       e_txr, e_rxr, e_ovr;
    logic [7:0] e_rd;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1,1,0,1,8'h01,0,8'h00,0,0, 1,0,0,8'h00}, // R2 enable on
    '{1,0,0,1,8'hA5,0,8'h00,0,0, 0,0,0,8'h00}, // R3 data write
    '{0,0,0,0,8'h00,0,8'h00,1,1, 1,0,0,8'h00}, // R4 start frees
    '{0,0,0,1,8'h3C,0,8'h00,0,0, 1,0,0,8'h00}, // R7 unselected write
    '{0,0,0,0,8'h00,1,8'h5A,0,0, 1,1,0,8'h5A}, // R5 char in
    '{1,1,1,0,8'h00,0,8'h00,0,0, 1,1,0,8'h5A}, // R7 command read
    '{1,0,1,0,8'h00,0,8'h00,0,0, 1,0,0,8'h5A}, // R6 data read
    '{0,0,0,0,8'h00,1,8'h11,0,0, 1,1,0,8'h11}, // R5
    '{0,0,0,0,8'h00,1,8'h22,0,0, 1,1,1,8'h22}, // R8 overwrite
    '{1,0,1,0,8'h00,1,8'h33,0,0, 1,1,1,8'h33}, // R9 read with char
    '{1,1,0,1,8'h10,0,8'h00,0,0, 0,1,0,8'h33}, // R10 clear, R2 enable off
    '{1,1,0,1,8'h01,0,8'h00,0,0, 1,1,0,8'h33}  // R2 enable on
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle_in();
    sel = 0; is_cmd = 0; rd_stb = 0; wr_stb = 0; wr_data = 0;
    rx_done = 0; rx_char = 0; shift_done = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  initial begin
    #150000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0;
    idle_in(); cts_ok = 0; shift_idle = 0; shift_txd = 1;
    rst_n = 0;
    #3;
    chk("R1 tx_ready", tx_ready, 0);
    chk("R1 txd", txd, 1);
    repeat (2) tick();
    rst_n = 1;
    repeat (3) tick();
    chk("R1 rx_ready", rx_ready, 0);
    chk("R1 overrun", overrun, 0);
    chk("R1 tx_start", tx_start, 0);
    chk("R1 txd", txd, 1);

    for (int i = 0; i < NV; i++) begin
      sel = VEC[i].s; is_cmd = VEC[i].c; rd_stb = VEC[i].r; wr_stb = VEC[i].w;
      wr_data = VEC[i].wd; rx_done = VEC[i].rxd; rx_char = VEC[i].rxc;
      cts_ok = VEC[i].cts; shift_idle = VEC[i].idle;
      tick();
      chk($sformatf("vec%0d tx_ready R2/R3/R4", i), tx_ready, VEC[i].e_txr);
      chk($sformatf("vec%0d rx_ready R5/R6/R9", i), rx_ready, VEC[i].e_rxr);
      chk($sformatf("vec%0d overrun R8/R10", i), overrun, VEC[i].e_ovr);
      chk($sformatf("vec%0d rd_data R5", i), rd_data, VEC[i].e_rd);
    end
    idle_in(); cts_ok = 0; shift_idle = 0;

    // R11: the vec2 start gave the line to the shifter
    shift_txd = 0; #1;
    chk("R11 txd follows shifter", txd, 0);
    shift_done = 1; tick(); shift_done = 0; #1;
    chk("R11 txd mark after done", txd, 1);

    // R4 gating: full, enabled, vary cts and idle
    sel = 1; wr_stb = 1; wr_data = 8'h96; tick(); idle_in();
    cts_ok = 0; shift_idle = 1; #1;
    chk("R4 no start without cts", tx_start, 0);
    cts_ok = 1; shift_idle = 0; #1;
    chk("R4 no start while busy", tx_start, 0);
    shift_idle = 1; #1;
    chk("R4 start", tx_start, 1);
    chk("R4 tx_byte", tx_byte, 8'h96);
    tick(); shift_idle = 0; #1;
    chk("R4 empty after start", tx_ready, 1);
    chk("R11 txd owned", txd, 0);
    shift_done = 1; tick(); shift_done = 0;

    // R2: disabled transmitter holds the byte back
    sel = 1; is_cmd = 1; wr_stb = 1; wr_data = 8'h00; tick();
    is_cmd = 0; wr_data = 8'h4B; tick(); idle_in();
    shift_idle = 1; #1;
    chk("R2 ready low when disabled", tx_ready, 0);
    chk("R2 no start when disabled", tx_start, 0);
    sel = 1; is_cmd = 1; wr_stb = 1; wr_data = 8'h01; tick(); idle_in(); #1;
    chk("R2 start after enable", tx_start, 1);
    chk("R2 byte kept", tx_byte, 8'h4B);
    tick(); shift_idle = 0;

    // R10: overrun sticky against a plain command write
    rx_done = 1; rx_char = 8'h01; tick();
    rx_char = 8'h02; tick(); idle_in();
    sel = 1; is_cmd = 1; wr_stb = 1; wr_data = 8'h01; tick(); idle_in();
    chk("R10 overrun sticky", overrun, 1);

    // R1: asynchronous reset mid-operation
    #2 rst_n = 0; #1;
    chk("R1 rx_ready async", rx_ready, 0);
    chk("R1 overrun async", overrun, 0);
    chk("R1 txd async", txd, 1);
    tick(); rst_n = 1; repeat (3) tick();
    chk("R1 tx_ready after reset", tx_ready, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule